// File: doc/BRIEF.md
# Radio Front-End Pin Controller

This block sits between the digital core of a narrowband transceiver and its package pins. An 8-bit configuration word, loaded through a write strobe, decides how the pins behave. It sets the direction of the bidirectional data pin. It moves receive data onto an alternate pin when split data pins are chosen. It gates the data clock with PLL lock and with carrier sense. It drives the enables for an external power amplifier and an external low-noise amplifier with a programmable polarity. It also powers down the crystal oscillator when an external clock is used.

Two further duties are handled here. When either test enable is raised, the low nibble of the configuration word is handed to the analog test module. When split data pins are chosen, a falling edge on the bidirectional pin can request the power-up sequencer to start. That pin input passes through a synchronizer before its edges are detected. Every pin-facing output is registered, so each output shows the configuration and inputs that were present one clock edge earlier. Analog circuits, the oscillator and the sequencer are outside this block and appear only as ports.

Top module: `rf_pin_ctrl`

## Requirements
- R1: On synchronous reset, all eight configuration bits become 0 and a write with `cfg_we` high loads `cfg_din` at the next edge. After reset with default configuration, `pa_en` and `lna_en` are 0, `xosc_pd` is 0, `test_pd` is 1 and `test_mode` is 3'b001.
- R2: `xosc_pd` follows configuration bit 7. The value 1 powers down the internal oscillator and selects a full-swing external clock.
- R3: With bit 6 at 0, `data_pin_oe` equals `rx_mode` (1 means receive), `data_pin_out` carries `rx_data`, and `lock_pin_out` carries `pll_lock`.
- R4: With bit 6 at 1, `data_pin_oe` is 0. In synchronous mode (`sync_mode`=1), `lock_pin_out` carries `rx_data`. In asynchronous mode, `dclk_pin_out` carries `rx_data` and `lock_pin_out` carries `pll_lock`.
- R5: In synchronous mode, bit 5 at 1 forces `dclk_pin_out` to 1 while `pll_lock` is 0, but only when `pd_mode` equals 2'b01. Otherwise the data clock is passed through ungated.
- R6: In synchronous mode, bit 4 at 1 forces `dclk_pin_out` to 1 while `carrier_sense` is 0 in receive. In transmit (`rx_mode`=0), bit 4 has no effect.
- R7: `pa_en` equals bit 1 (PA polarity) when bit 3 is 0. When bit 3 is 1, `pa_en` equals bit 1 while `int_pa_on` is 1 and its inverse otherwise. A polarity of 1 means active-high and 0 means active-low.
- R8: `lna_en` behaves the same way, with bit 2 as the follow select, bit 0 as the polarity and `int_lna_on` as the internal state.
- R9: When `test_en_a` or `test_en_b` is 1, `test_pd` carries bit 3 and `test_mode` carries bits 2:0. Otherwise `test_pd` is 1 and `test_mode` is 3'b001.
- R10: When bit 6 is 1, `seq_psel` is 0 and `pd_mode` is 2'b11, a falling edge on `data_pin_in` raises `seq_start` for exactly one cycle. The pulse appears on the third clock edge after the edge on the pin.
- R11: `seq_start` stays 0 for rising edges, for a steady pin, and for falling edges when any enabling condition of R10 is missing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_din | input | 8 | Configuration write data |
| rx_mode | input | 1 | 1 = receive, 0 = transmit |
| sync_mode | input | 1 | 1 = synchronous data mode, 0 = asynchronous |
| pd_mode | input | 2 | Power-down mode field |
| seq_psel | input | 1 | Sequencing pin-select bit |
| pll_lock | input | 1 | PLL lock status |
| carrier_sense | input | 1 | Carrier sense indicator |
| int_pa_on | input | 1 | Internal PA is powered |
| int_lna_on | input | 1 | Internal LNA is powered |
| test_en_a | input | 1 | First analog test enable |
| test_en_b | input | 1 | Second analog test enable |
| rx_data | input | 1 | Demodulated receive data |
| dclk_int | input | 1 | Internal data clock |
| data_pin_in | input | 1 | Asynchronous input from the bidirectional data pin |
| xosc_pd | output | 1 | Oscillator power-down / external clock select |
| data_pin_oe | output | 1 | Output enable of the bidirectional data pin |
| data_pin_out | output | 1 | Output value of the bidirectional data pin |
| lock_pin_out | output | 1 | Lock pin value |
| dclk_pin_out | output | 1 | Data clock pin value |
| pa_en | output | 1 | External PA enable |
| lna_en | output | 1 | External LNA enable |
| test_pd | output | 1 | Analog test power-down |
| test_mode | output | 3 | Analog test mode select |
| seq_start | output | 1 | One-cycle request to start power-up sequencing |

## Verification
Random configuration words are crossed with random receive/transmit, synchronous/asynchronous, lock, carrier and internal amplifier states. This reaches every routing combination of the data, lock and clock pins and every polarity/follow pairing of the two enables. Directed cases hold the data clock low so that any gating shows up as a 1. They separate a lock gate that is wrongly applied outside power-down mode 01, and a carrier gate that leaks into transmit, from the correct pass-through. Edge-request cases drive falling and rising pin transitions with and without the enabling conditions. They check both the pulse count and the cycle in which the pulse appears, which exposes a wrong synchronizer depth or a missing edge qualifier.

// File: rtl/rf_pin_pkg.sv
package rf_pin_pkg;
  localparam int CFG_W        = 8;
  localparam int B_XOSC_BYP   = 7;
  localparam int B_SPLIT_DATA = 6;
  localparam int B_LOCK_GATE  = 5;
  localparam int B_CS_GATE    = 4;
  localparam int B_PA_FOLLOW  = 3;
  localparam int B_LNA_FOLLOW = 2;
  localparam int B_PA_POL     = 1;
  localparam int B_LNA_POL    = 0;
  localparam int TEST_MODE_W  = 3;

  localparam logic [1:0] PD_LOCK_GATE = 2'b01;
  localparam logic [1:0] PD_SEQ_EN    = 2'b11;
  localparam logic [TEST_MODE_W-1:0] TEST_MODE_IDLE = 3'b001;

  typedef struct packed {
    logic oe;
    logic dio;
    logic lock;
    logic dclk;
  } pin_route_t;
endpackage

// File: rtl/rf_cfg_reg.sv
module rf_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= din;
  end
endmodule

// File: rtl/rf_pin_route.sv
module rf_pin_route
  import rf_pin_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       split_data,
  input  logic       lock_gate_en,
  input  logic       cs_gate_en,
  input  logic       rx_mode,
  input  logic       sync_mode,
  input  logic [1:0] pd_mode,
  input  logic       pll_lock,
  input  logic       carrier_sense,
  input  logic       rx_data,
  input  logic       dclk_int,
  output pin_route_t route
);
  logic       hold_lock;
  logic       hold_cs;
  logic       dclk_sync;
  pin_route_t nxt;

  always_comb begin
    // gating drives the clock pin high while the qualifying status is absent
    hold_lock = lock_gate_en && (pd_mode == PD_LOCK_GATE) && !pll_lock;
    hold_cs   = cs_gate_en && rx_mode && !carrier_sense;
    dclk_sync = dclk_int | hold_lock | hold_cs;

    nxt.oe   = rx_mode && !split_data;
    nxt.dio  = rx_data;
    nxt.lock = (split_data && sync_mode) ? rx_data : pll_lock;
    if (sync_mode)       nxt.dclk = dclk_sync;
    else if (split_data) nxt.dclk = rx_data;
    else                 nxt.dclk = dclk_int;
  end

  always_ff @(posedge clk) begin
    if (rst) route <= '{oe: 1'b0, dio: 1'b0, lock: 1'b0, dclk: 1'b1};
    else     route <= nxt;
  end
endmodule

// File: rtl/rf_ext_enable.sv
module rf_ext_enable (
  input  logic clk,
  input  logic rst,
  input  logic follow,
  input  logic pol,
  input  logic int_on,
  output logic en
);
  logic active;
  always_comb active = follow ? int_on : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) en <= 1'b0;
    else     en <= active ? pol : ~pol;
  end
endmodule

// File: rtl/rf_seq_edge.sv
module rf_seq_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic pin,
  output logic pulse
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '1;
    else     shreg <= {shreg[LAST-1:0], pin};
  end

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= arm && shreg[LAST] && !shreg[LAST-1];
  end
endmodule

// File: rtl/rf_pin_ctrl.sv
module rf_pin_ctrl
  import rf_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [CFG_W-1:0]       cfg_din,
  input  logic                   rx_mode,
  input  logic                   sync_mode,
  input  logic [1:0]             pd_mode,
  input  logic                   seq_psel,
  input  logic                   pll_lock,
  input  logic                   carrier_sense,
  input  logic                   int_pa_on,
  input  logic                   int_lna_on,
  input  logic                   test_en_a,
  input  logic                   test_en_b,
  input  logic                   rx_data,
  input  logic                   dclk_int,
  input  logic                   data_pin_in,
  output logic                   xosc_pd,
  output logic                   data_pin_oe,
  output logic                   data_pin_out,
  output logic                   lock_pin_out,
  output logic                   dclk_pin_out,
  output logic                   pa_en,
  output logic                   lna_en,
  output logic                   test_pd,
  output logic [TEST_MODE_W-1:0] test_mode,
  output logic                   seq_start
);
  localparam int N_AMP = 2;

  logic [CFG_W-1:0] cfg_q;
  pin_route_t       route;
  logic [N_AMP-1:0] amp_follow, amp_pol, amp_on, amp_en;
  logic             seq_arm;
  logic             test_on;

  rf_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .din(cfg_din), .q(cfg_q)
  );

  rf_pin_route u_route (
    .clk(clk), .rst(rst),
    .split_data(cfg_q[B_SPLIT_DATA]),
    .lock_gate_en(cfg_q[B_LOCK_GATE]),
    .cs_gate_en(cfg_q[B_CS_GATE]),
    .rx_mode(rx_mode), .sync_mode(sync_mode), .pd_mode(pd_mode),
    .pll_lock(pll_lock), .carrier_sense(carrier_sense),
    .rx_data(rx_data), .dclk_int(dclk_int),
    .route(route)
  );

  assign data_pin_oe  = route.oe;
  assign data_pin_out = route.dio;
  assign lock_pin_out = route.lock;
  assign dclk_pin_out = route.dclk;

  // channel 0 = power amplifier, channel 1 = low-noise amplifier
  assign amp_follow = {cfg_q[B_LNA_FOLLOW], cfg_q[B_PA_FOLLOW]};
  assign amp_pol    = {cfg_q[B_LNA_POL], cfg_q[B_PA_POL]};
  assign amp_on     = {int_lna_on, int_pa_on};

  for (genvar i = 0; i < N_AMP; i++) begin : g_amp
    rf_ext_enable u_en (
      .clk(clk), .rst(rst),
      .follow(amp_follow[i]), .pol(amp_pol[i]), .int_on(amp_on[i]),
      .en(amp_en[i])
    );
  end

  assign pa_en  = amp_en[0];
  assign lna_en = amp_en[1];

  assign seq_arm = cfg_q[B_SPLIT_DATA] && !seq_psel && (pd_mode == PD_SEQ_EN);

  rf_seq_edge #(.SYNC_STAGES(SYNC_STAGES)) u_seq (
    .clk(clk), .rst(rst), .arm(seq_arm), .pin(data_pin_in), .pulse(seq_start)
  );

  assign test_on = test_en_a | test_en_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      xosc_pd   <= 1'b0;
      test_pd   <= 1'b1;
      test_mode <= TEST_MODE_IDLE;
    end else begin
      xosc_pd   <= cfg_q[B_XOSC_BYP];
      test_pd   <= test_on ? cfg_q[B_PA_FOLLOW] : 1'b1;
      test_mode <= test_on ? cfg_q[TEST_MODE_W-1:0] : TEST_MODE_IDLE;
    end
  end
endmodule

// File: rtl/rf_pin_ctrl_chk.sv
module rf_pin_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] cfg_q,
  input logic       rx_mode,
  input logic       sync_mode,
  input logic       dclk_int,
  input logic       test_en_a,
  input logic       test_en_b,
  input logic       xosc_pd,
  input logic       data_pin_oe,
  input logic       dclk_pin_out,
  input logic       pa_en,
  input logic       test_pd,
  input logic [2:0] test_mode,
  input logic       seq_start
);
  AST_XOSC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    cfg_q[7] |=> xosc_pd); // R2

  AST_SPLIT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    cfg_q[6] |=> !data_pin_oe); // R4

  AST_TX_NO_CS_GATE: assert property (@(posedge clk) disable iff (rst)
    (!rx_mode && sync_mode && !cfg_q[6] && !cfg_q[5]) |=> (dclk_pin_out == $past(dclk_int))); // R6

  AST_PA_FIXED_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !cfg_q[3] |=> (pa_en == $past(cfg_q[1]))); // R7

  AST_TEST_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!test_en_a && !test_en_b) |=> (test_pd && test_mode == 3'b001)); // R9

  AST_SEQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> !seq_start); // R10
endmodule

bind rf_pin_ctrl rf_pin_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cfg_q(cfg_q), .rx_mode(rx_mode), .sync_mode(sync_mode),
  .dclk_int(dclk_int), .test_en_a(test_en_a), .test_en_b(test_en_b),
  .xosc_pd(xosc_pd), .data_pin_oe(data_pin_oe), .dclk_pin_out(dclk_pin_out),
  .pa_en(pa_en), .test_pd(test_pd), .test_mode(test_mode), .seq_start(seq_start)
);

// File: tb/rf_pin_ctrl_tb.sv
`timescale 1ns/1ps
module rf_pin_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_din = 8'h00;
  logic rx_mode = 0, sync_mode = 0, seq_psel = 0, pll_lock = 0, carrier_sense = 0;
  logic [1:0] pd_mode = 2'b00;
  logic int_pa_on = 0, int_lna_on = 0, test_en_a = 0, test_en_b = 0;
  logic rx_data = 0, dclk_int = 0, data_pin_in = 1'b1;
  logic xosc_pd, data_pin_oe, data_pin_out, lock_pin_out, dclk_pin_out;
  logic pa_en, lna_en, test_pd, seq_start;
  logic [2:0] test_mode;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rf_pin_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_din(cfg_din),
    .rx_mode(rx_mode), .sync_mode(sync_mode), .pd_mode(pd_mode), .seq_psel(seq_psel),
    .pll_lock(pll_lock), .carrier_sense(carrier_sense),
    .int_pa_on(int_pa_on), .int_lna_on(int_lna_on),
    .test_en_a(test_en_a), .test_en_b(test_en_b),
    .rx_data(rx_data), .dclk_int(dclk_int), .data_pin_in(data_pin_in),
    .xosc_pd(xosc_pd), .data_pin_oe(data_pin_oe), .data_pin_out(data_pin_out),
    .lock_pin_out(lock_pin_out), .dclk_pin_out(dclk_pin_out),
    .pa_en(pa_en), .lna_en(lna_en), .test_pd(test_pd), .test_mode(test_mode),
    .seq_start(seq_start)
  );

  typedef struct packed {
    logic oe, dio, lock, dclk, pa, lna, xo, tpd;
    logic [2:0] tm;
  } exp_t;

  function automatic exp_t model(input logic [7:0] c);
    exp_t e;
    logic gate;
    e.oe   = rx_mode & ~c[6];
    e.dio  = rx_data;
    e.lock = (c[6] & sync_mode) ? rx_data : pll_lock;
    gate   = (c[5] & (pd_mode == 2'b01) & ~pll_lock) | (c[4] & rx_mode & ~carrier_sense);
    if (!sync_mode) e.dclk = c[6] ? rx_data : dclk_int;
    else            e.dclk = dclk_int | gate;
    e.pa   = c[3] ? (int_pa_on ? c[1] : ~c[1]) : c[1];
    e.lna  = c[2] ? (int_lna_on ? c[0] : ~c[0]) : c[0];
    e.xo   = c[7];
    e.tpd  = (test_en_a | test_en_b) ? c[3] : 1'b1;
    e.tm   = (test_en_a | test_en_b) ? c[2:0] : 3'b001;
    return e;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic compare_all(input logic [7:0] c);
    exp_t e = model(c);
    chk("R3_R4 data_pin_oe",  {7'd0, data_pin_oe},  {7'd0, e.oe});
    chk("R3 data_pin_out",    {7'd0, data_pin_out}, {7'd0, e.dio});
    chk("R3_R4 lock_pin_out", {7'd0, lock_pin_out}, {7'd0, e.lock});
    chk("R5_R6 dclk_pin_out", {7'd0, dclk_pin_out}, {7'd0, e.dclk});
    chk("R7 pa_en",           {7'd0, pa_en},        {7'd0, e.pa});
    chk("R8 lna_en",          {7'd0, lna_en},       {7'd0, e.lna});
    chk("R2 xosc_pd",         {7'd0, xosc_pd},      {7'd0, e.xo});
    chk("R9 test_pd",         {7'd0, test_pd},      {7'd0, e.tpd});
    chk("R9 test_mode",       {5'd0, test_mode},    {5'd0, e.tm});
    chk("R11 seq_start idle", {7'd0, seq_start},    8'd0);
  endtask

  // load config (already driven with other inputs), let two edges pass, sample
  task automatic settle_and_check(input logic [7:0] c);
    cfg_din = c;
    cfg_we  = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    compare_all(c);
  endtask

  task automatic seq_case(input string req, input logic sep, input logic psel,
                          input logic [1:0] pdm, input logic rising, input int exp_n);
    int cnt = 0;
    int first = 0;
    cfg_din = {1'b0, sep, 6'b0};
    cfg_we = 1'b1; seq_psel = psel; pd_mode = pdm;
    data_pin_in = rising ? 1'b0 : 1'b1;
    repeat (5) @(negedge clk);
    data_pin_in = ~data_pin_in;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (seq_start) begin
        cnt++;
        if (first == 0) first = k;
      end
    end
    chk({req, " pulse count"}, cnt[7:0], exp_n[7:0]);
    if (exp_n > 0) chk({req, " pulse cycle"}, first[7:0], 8'd3);
    data_pin_in = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R1: reset state, default configuration
    chk("R1 pa_en reset",     {7'd0, pa_en},     8'd0);
    chk("R1 lna_en reset",    {7'd0, lna_en},    8'd0);
    chk("R1 xosc_pd reset",   {7'd0, xosc_pd},   8'd0);
    chk("R1 test_pd reset",   {7'd0, test_pd},   8'd1);
    chk("R1 test_mode reset", {5'd0, test_mode}, 8'd1);
    compare_all(8'h00);

    // R5: lock gate only in power-down mode 01, synchronous
    sync_mode = 1; rx_mode = 1; carrier_sense = 1; pll_lock = 0; dclk_int = 0;
    pd_mode = 2'b10;
    settle_and_check(8'h20);
    chk("R5 lock gate off outside pd 01", {7'd0, dclk_pin_out}, 8'd0);
    pd_mode = 2'b01;
    settle_and_check(8'h20);
    chk("R5 lock gate forces 1", {7'd0, dclk_pin_out}, 8'd1);
    pll_lock = 1;
    settle_and_check(8'h20);
    chk("R5 locked passes clock", {7'd0, dclk_pin_out}, 8'd0);

    // R6: carrier gate in receive only
    pd_mode = 2'b00; carrier_sense = 0; rx_mode = 1;
    settle_and_check(8'h10);
    chk("R6 cs gate in receive", {7'd0, dclk_pin_out}, 8'd1);
    rx_mode = 0;
    settle_and_check(8'h10);
    chk("R6 cs gate ignored in transmit", {7'd0, dclk_pin_out}, 8'd0);

    // R4: split pins, async puts data on clock pin
    sync_mode = 0; rx_mode = 1; rx_data = 1; dclk_int = 0;
    settle_and_check(8'h40);
    chk("R4 async data on dclk", {7'd0, dclk_pin_out}, 8'd1);
    chk("R4 split pin not driven", {7'd0, data_pin_oe}, 8'd0);

    // R7/R8: follow with internal amp off inverts polarity
    int_pa_on = 0; int_lna_on = 0;
    settle_and_check(8'h0F);
    chk("R7 follow, PA off", {7'd0, pa_en}, 8'd0);
    chk("R8 follow, LNA off", {7'd0, lna_en}, 8'd0);
    int_pa_on = 1; int_lna_on = 1;
    settle_and_check(8'h0F);
    chk("R7 follow, PA on", {7'd0, pa_en}, 8'd1);
    chk("R8 follow, LNA on", {7'd0, lna_en}, 8'd1);

    // R9: each test enable alone
    test_en_a = 1;
    settle_and_check(8'h06);
    chk("R9 test mode from low bits", {5'd0, test_mode}, 8'd6);
    test_en_a = 0; test_en_b = 1;
    settle_and_check(8'h0B);
    chk("R9 test pd from bit 3", {7'd0, test_pd}, 8'd1);
    test_en_b = 0;

    // R10/R11: sequencing start edge
    seq_case("R10 falling armed", 1'b1, 1'b0, 2'b11, 1'b0, 1);
    seq_case("R11 rising armed", 1'b1, 1'b0, 2'b11, 1'b1, 0);
    seq_case("R11 no split", 1'b0, 1'b0, 2'b11, 1'b0, 0);
    seq_case("R11 psel set", 1'b1, 1'b1, 2'b11, 1'b0, 0);
    seq_case("R11 pd not 3", 1'b1, 1'b0, 2'b01, 1'b0, 0);

    // random sweep, pin held steady
    data_pin_in = 1'b1;
    for (int i = 0; i < 400; i++) begin
      rx_mode = $urandom; sync_mode = $urandom; pd_mode = $urandom;
      seq_psel = $urandom; pll_lock = $urandom; carrier_sense = $urandom;
      int_pa_on = $urandom; int_lna_on = $urandom;
      test_en_a = (($urandom % 4) == 0); test_en_b = (($urandom % 4) == 0);
      rx_data = $urandom; dclk_int = $urandom;
      settle_and_check(8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule